// File: doc/BRIEF.md
# Two-Key Register Write-Protection Gate

This block sits between a simple register bus and the register file of a peripheral. It keeps stray writes from reaching that file. Two key registers, each 32 bits wide and each at its own address, form a lock. Software opens the lock by loading the first key register with its magic value and then the second key register with its own magic value. While the lock is open, the block forwards writes to the protected register file as a registered write strobe, together with the captured address and data.

Any write of a non-key value to either key register closes the lock again on that same clock edge. The usual way to close it is to write zero to both. Reads are never blocked. Read data from the register file passes straight through, except that the two key registers always read back as zero. The lock is closed after reset.

Top module: `regfile_write_guard`

## Requirements
- R1: After a synchronous reset the lock is closed (`unlocked` = 0) and `rf_wr` is 0.
- R2: Writing 32'h83E70B13 to byte offset 8'h6C (first key) and then 32'h95A4F1E0 to offset 8'h70 (second key) opens the lock. `unlocked` reads 1 in the cycle after the second-key write.
- R3: A correct second-key write opens nothing unless the first key register already holds its key. Writing the keys in reverse order leaves the lock closed.
- R4: A second-key write with any value other than its key leaves the lock closed. A non-key write to the first key register after its key was loaded disarms it, so a following correct second-key write does not open the lock.
- R5: While open, a write of any non-key value (zero or otherwise) to either key register closes the lock. `unlocked` reads 0 in the following cycle, and protected writes after it are blocked.
- R6: While closed, a write to any address other than the two key offsets produces no `rf_wr` pulse.
- R7: While open, a write to any address other than the two key offsets produces an `rf_wr` pulse one cycle later, with `rf_addr` and `rf_wdata` equal to the bus address and data. Back-to-back writes each produce their own pulse.
- R8: Writes to the key offsets are never forwarded as `rf_wr`, whether the lock is open or closed.
- R9: `bus_rdata` is 0 when `bus_addr` is a key offset. At every other address it equals `rf_rdata`, whether the lock is open or closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one write per asserted cycle |
| bus_addr | input | 8 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| rf_rdata | input | 32 | Read data from the protected register file |
| bus_rdata | output | 32 | Read data returned to the bus |
| rf_wr | output | 1 | Registered, gated write strobe to the register file |
| rf_addr | output | 8 | Registered write address to the register file |
| rf_wdata | output | 32 | Registered write data to the register file |
| unlocked | output | 1 | Lock is open |

## Verification
The key sequence is driven in the following patterns:
- the correct order;
- the reverse order;
- the first key alone;
- the second key alone;
- an off-by-one second key;
- a first key that is overwritten before the second key arrives.

Together these separate "second key seen" from "both keys seen in order". Protected writes are placed right before and right after each lock change, which pins down the edge on which the gate changes. Back-to-back protected writes and key writes made while the lock is open show that the strobe is produced per write and that key writes are never forwarded. Relocking is tried with zero and with a non-zero wrong value on each key register, so that an implementation that relocks only on zero, or only through one register, is told apart from a correct one.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  typedef enum logic [1:0] {
    KSEL_NONE = 2'd0,
    KSEL_FIRST = 2'd1,
    KSEL_SECOND = 2'd2
  } kick_sel_e;
endpackage

// File: rtl/kick_decode.sv
module kick_decode
  import rwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KICK0_OFS = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK1_OFS = 8'h70,
  parameter logic [DATA_W-1:0] KEY0 = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1 = 32'h95A4F1E0
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output kick_sel_e         sel,
  output logic              key_ok,
  output logic              prot_wr
);
  always_comb begin
    sel = KSEL_NONE;
    key_ok = 1'b0;
    if (addr == KICK0_OFS) begin
      sel = KSEL_FIRST;
      key_ok = (wdata == KEY0);
    end else if (addr == KICK1_OFS) begin
      sel = KSEL_SECOND;
      key_ok = (wdata == KEY1);
    end
    prot_wr = wr && (sel == KSEL_NONE);
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import rwg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  kick_sel_e sel,
  input  logic      key_ok,
  output logic      unlocked
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      unlocked <= 1'b0;
    end else if (wr) begin
      case (sel)
        KSEL_FIRST: begin
          if (key_ok) begin
            armed <= 1'b1;
          end else begin
            armed    <= 1'b0;
            unlocked <= 1'b0;
          end
        end
        KSEL_SECOND: begin
          unlocked <= key_ok && armed;
        end
        default: ;
      endcase
    end
  end

  // R2 R3
  unlock_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(wr && sel == KSEL_SECOND && key_ok && armed));

  // R5
  relock_on_bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel != KSEL_NONE && !key_ok) |=> !unlocked);
endmodule

// File: rtl/write_gate.sv
module write_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              prot_wr,
  input  logic              open_now,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rf_wr,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rf_wr    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
    end else begin
      rf_wr <= prot_wr && open_now;
      if (prot_wr && open_now) begin
        rf_addr  <= addr;
        rf_wdata <= wdata;
      end
    end
  end

  // R6
  locked_block_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_wr && !open_now) |=> !rf_wr);

  // R7
  open_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_wr && open_now) |=> (rf_wr && rf_wdata == $past(wdata) && rf_addr == $past(addr)));

  // R8
  kick_no_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !prot_wr) |=> !rf_wr);
endmodule

// File: rtl/regfile_write_guard.sv
module regfile_write_guard
  import rwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KICK0_OFS = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK1_OFS = 8'h70,
  parameter logic [DATA_W-1:0] KEY0 = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1 = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rf_wr,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              unlocked
);
  kick_sel_e sel;
  logic      key_ok;
  logic      prot_wr;

  kick_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KICK0_OFS(KICK0_OFS), .KICK1_OFS(KICK1_OFS),
    .KEY0(KEY0), .KEY1(KEY1)
  ) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .sel(sel), .key_ok(key_ok), .prot_wr(prot_wr)
  );

  lock_fsm u_fsm (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel),
    .key_ok(key_ok), .unlocked(unlocked)
  );

  write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst(rst), .wr(bus_wr), .prot_wr(prot_wr),
    .open_now(unlocked), .addr(bus_addr), .wdata(bus_wdata),
    .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
  );

  // R9: key registers read as zero, all else passes through
  assign bus_rdata = (sel == KSEL_NONE) ? rf_rdata : '0;
endmodule

// File: tb/regfile_write_guard_test.sv
module regfile_write_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  K0A = 8'h6C;
  localparam logic [7:0]  K1A = 8'h70;
  localparam logic [31:0] K0V = 32'h83E70B13;
  localparam logic [31:0] K1V = 32'h95A4F1E0;

  typedef struct {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic        unl;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rf_rdata = '0;
  logic [31:0] bus_rdata;
  logic rf_wr;
  logic [7:0] rf_addr;
  logic [31:0] rf_wdata;
  logic unlocked;

  int checks = 0;
  int fails = 0;
  exp_t sb[$];
  logic m_arm = 1'b0;
  logic m_unl = 1'b0;
  logic active = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_write_guard uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rf_rdata(rf_rdata), .bus_rdata(bus_rdata),
    .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .unlocked(unlocked)
  );

  // monitor: compare outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (active && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rf_wr !== e.wr || unlocked !== e.unl ||
          (e.wr && (rf_addr !== e.addr || rf_wdata !== e.data))) begin
        fails++;
        $display("FAIL %s: rf_wr=%0b unl=%0b addr=%h data=%h expected rf_wr=%0b unl=%0b addr=%h data=%h",
                 e.tag, rf_wr, unlocked, rf_addr, rf_wdata, e.wr, e.unl, e.addr, e.data);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    e.wr = (a != K0A && a != K1A) && m_unl;
    e.addr = a; e.data = d; e.tag = tag;
    if (a == K0A) begin
      if (d == K0V) m_arm = 1'b1;
      else begin m_arm = 1'b0; m_unl = 1'b0; end
    end else if (a == K1A) begin
      m_unl = (d == K1V) && m_arm;
    end
    e.unl = m_unl;
    sb.push_back(e);
  endtask

  task automatic bus_idle(input string tag);
    exp_t e;
    @(negedge clk);
    bus_wr = 1'b0;
    e.wr = 1'b0; e.addr = '0; e.data = '0; e.unl = m_unl; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] rfd, input string tag);
    logic [31:0] expv;
    bus_idle(tag);
    bus_addr = a; rf_rdata = rfd;
    expv = (a == K0A || a == K1A) ? 32'h0 : rfd;
    #1;
    checks++;
    if (bus_rdata !== expv) begin
      fails++;
      $display("FAIL %s: bus_rdata=%h expected %h", tag, bus_rdata, expv);
    end
  endtask

  task automatic open_lock(input string tag);
    bus_write(K0A, K0V, tag);
    bus_write(K1A, K1V, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (unlocked !== 1'b0 || rf_wr !== 1'b0) begin
      fails++;
      $display("FAIL R1: unlocked=%0b rf_wr=%0b expected 0 0", unlocked, rf_wr);
    end
    active = 1'b1;
    // R6 closed lock blocks protected writes
    bus_write(8'h04, 32'h11, "R6");
    bus_write(8'h40, 32'h22, "R6");
    // R3 second key alone, then reversed order
    bus_write(K1A, K1V, "R3");
    bus_write(8'h08, 32'h33, "R3");
    bus_write(K1A, K1V, "R3");
    bus_write(K0A, K0V, "R3");
    bus_write(8'h08, 32'h34, "R3");
    bus_write(K0A, 32'h0, "R3");
    // R4 wrong second key, disarmed first key
    bus_write(K0A, K0V, "R4");
    bus_write(K1A, K1V ^ 32'h1, "R4");
    bus_write(8'h0C, 32'h44, "R4");
    bus_write(K0A, K0V, "R4");
    bus_write(K0A, 32'h0, "R4");
    bus_write(K1A, K1V, "R4");
    bus_write(8'h0C, 32'h45, "R4");
    // R2 correct order
    open_lock("R2");
    bus_idle("R2");
    // R7 back-to-back protected writes
    bus_write(8'h00, 32'hDEADBEEF, "R7");
    bus_write(8'h40, 32'h00000008, "R7");
    bus_write(8'h98, 32'h00010000, "R7");
    bus_idle("R7");
    // R8 key writes while open are not forwarded
    bus_write(K0A, K0V, "R8");
    bus_write(K1A, K1V, "R8");
    bus_write(8'h14, 32'h25, "R8");
    // R9 reads while open and closed
    bus_read(K0A, 32'hAAAA5555, "R9");
    bus_read(K1A, 32'h12345678, "R9");
    bus_read(8'h14, 32'hCAFEF00D, "R9");
    // R5 relock by zero on second key
    bus_write(K1A, 32'h0, "R5");
    bus_write(8'h10, 32'h66, "R5");
    bus_read(8'h10, 32'h0000_0066, "R9");
    // R5 relock by zero on first key
    open_lock("R5");
    bus_write(8'h10, 32'h67, "R5");
    bus_write(K0A, 32'h0, "R5");
    bus_write(8'h10, 32'h68, "R5");
    // R5 relock by non-zero wrong value
    open_lock("R5");
    bus_write(K0A, 32'h12345678, "R5");
    bus_write(8'h18, 32'h69, "R5");
    open_lock("R5");
    bus_write(K1A, 32'hFFFFFFFF, "R5");
    bus_write(8'h18, 32'h6A, "R5");
    bus_idle("R5");
    bus_idle("R5");
    @(posedge clk); #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule